// File: doc/BRIEF.md
# Memory Access Fault Checker

This block sits between the load, store and fetch logic of a processor core and the memory path. Each access is presented as an address, an access kind, a log2 size and a selector for one of three core flavours, plus two control bits: one that hides alignment faults and one that opens a protected RAM window. The block classifies the access into at most one fault and produces the address with its low bits forced to the natural alignment of the access size.

The three flavours treat alignment differently. Flavour A turns a misaligned data access into an access error unless the hide bit is set, and turns a misaligned fetch into an error. Flavour B raises a dedicated alignment fault. Flavour C clears the low bits without reporting anything. Each flavour also has its own set of reserved address windows, which raise either an access error or an access exception. A few of these windows depend on the protected RAM bit. The result is registered and appears one cycle after a request strobe.

Top module: `mem_fault_chk`

## Requirements
- R1: After reset `rsp_valid`, `rsp_fault` and `rsp_addr` are zero. `rsp_valid` is `req_valid` delayed by one clock. A request updates `rsp_fault` and `rsp_addr` on the next edge, and both hold their values while `req_valid` is low.
- R2: The access spans 2^`req_size` bytes, and a `req_size` above 4 counts as 16 bytes. `rsp_addr` is `req_addr` with its low `req_size` bits cleared. An access is misaligned when any of those low bits is set. All range checks use the corrected address, compare unsigned and include both bounds.
- R3: The fault codes are 0 for none, 1 for alignment, 2 for access error, 3 for store error and 4 for access exception. When several faults apply, the alignment fault wins, then the error codes, then the exception.
- R4: On flavour B (`req_core`=1), a misaligned read (`req_kind`=0), write (`req_kind`=1) or fetch (`req_kind`=2) reports code 1.
- R5: On flavour A (`req_core`=0), a misaligned read or write reports code 2 when `mask_align` is 0. It reports no alignment-related fault when `mask_align` is 1. A misaligned fetch reports code 2, and the range check is not applied to it.
- R6: On flavour A, an 8-byte read in 0xFE800000..0xFEFFFFFF reports code 2, and so does an aligned fetch in the same range. Writes in that range report nothing.
- R7: On flavour B, an access in 0xFE800000..0xFEFEFFFF or 0xFEFF0600..0xFEFF7FFF reports code 2 for a read and code 3 for a write.
- R8: On flavour B, a read or write in 0xFE000000..0xFE7FFFFF reports code 4.
- R9: On flavour B, a fetch in the R7 windows reports code 2. A fetch in 0xFE004000..0xFE7FFFFF reports code 4, and so does a fetch in 0xFE000000..0xFE003FFF while `prot_ram_en` is 0.
- R10: On flavour C (`req_core`=2), a read or write in 0xFE000000..0xFE3FFFFF or 0xFE408000..0xFE7FFFFF reports code 4, and so does one in 0xFE400000..0xFE407FFF while `prot_ram_en` is 0. Reads in 0xFE800000..0xFEFEFFFF report code 2 and writes there report code 3.
- R11: On flavour C, a fetch in 0xFE800000..0xFEFFFFFF reports code 2. A fetch in 0xFE008000..0xFE7FFFFF reports code 4, and so does a fetch in 0xFE000000..0xFE007FFF while `prot_ram_en` is 0.
- R12: On flavour C, misalignment never produces a fault. Only the corrected address reflects it.
- R13: `req_kind`=3 or `req_core`=3 always reports code 0, and the address is still corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_size | input | 3 | log2 of access bytes |
| req_core | input | 2 | 0 flavour A, 1 B, 2 C, 3 reserved |
| mask_align | input | 1 | Hides flavour A data alignment faults |
| prot_ram_en | input | 1 | Opens the protected RAM windows |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_fault | output | 3 | Fault code |
| rsp_addr | output | 32 | Aligned address |

## Verification
Several properties are checked on every cycle:
- the one-cycle response timing and the holding of results while the strobe is low;
- the clearing of the low address bits and the preservation of the upper bits;
- the legal code range;
- the forced alignment code on flavour B;
- the absence of an alignment code on flavours A and C;
- silence for reserved encodings.

Which window produces which code, the dependence on the protected RAM bit, and the interplay of priorities between windows are shown only by the bench. The bench sweeps every flavour, kind, size and control combination across addresses just inside and just outside every window bound.

// File: rtl/memchk_pkg.sv
package memchk_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CORE_A    = 2'd0,
    CORE_B    = 2'd1,
    CORE_C    = 2'd2,
    CORE_RSVD = 2'd3
  } core_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ALIGN  = 3'd1,
    FLT_ERROR  = 3'd2,
    FLT_STORE  = 3'd3,
    FLT_EXCEPT = 3'd4
  } fault_e;

  // window indices
  localparam int W_ERR_MAIN = 0;  // FE800000..FEFEFFFF
  localparam int W_ERR_SIDE = 1;  // FEFF0600..FEFF7FFF
  localparam int W_HI_FULL  = 2;  // FE800000..FEFFFFFF
  localparam int W_LO_FULL  = 3;  // FE000000..FE7FFFFF
  localparam int W_C_EXC_LO = 4;  // FE000000..FE3FFFFF
  localparam int W_C_EXC_HI = 5;  // FE408000..FE7FFFFF
  localparam int W_C_PRAM   = 6;  // FE400000..FE407FFF
  localparam int W_C_IEXC   = 7;  // FE008000..FE7FFFFF
  localparam int W_C_IPRAM  = 8;  // FE000000..FE007FFF
  localparam int W_B_IEXC   = 9;  // FE004000..FE7FFFFF
  localparam int W_B_IPRAM  = 10; // FE000000..FE003FFF
  localparam int NUM_WIN    = 11;

  function automatic logic [31:0] win_lo(input int idx);
    case (idx)
      W_ERR_MAIN: win_lo = 32'hFE80_0000;
      W_ERR_SIDE: win_lo = 32'hFEFF_0600;
      W_HI_FULL:  win_lo = 32'hFE80_0000;
      W_C_EXC_HI: win_lo = 32'hFE40_8000;
      W_C_PRAM:   win_lo = 32'hFE40_0000;
      W_C_IEXC:   win_lo = 32'hFE00_8000;
      W_B_IEXC:   win_lo = 32'hFE00_4000;
      default:    win_lo = 32'hFE00_0000;
    endcase
  endfunction

  function automatic logic [31:0] win_hi(input int idx);
    case (idx)
      W_ERR_MAIN: win_hi = 32'hFEFE_FFFF;
      W_ERR_SIDE: win_hi = 32'hFEFF_7FFF;
      W_HI_FULL:  win_hi = 32'hFEFF_FFFF;
      W_C_EXC_LO: win_hi = 32'hFE3F_FFFF;
      W_C_PRAM:   win_hi = 32'hFE40_7FFF;
      W_C_IPRAM:  win_hi = 32'hFE00_7FFF;
      W_B_IPRAM:  win_hi = 32'hFE00_3FFF;
      default:    win_hi = 32'hFE7F_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/mem_fault_align.sv
module mem_fault_align #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 3,
  parameter int MAX_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size_log2,
  output logic [ADDR_W-1:0] corrected,
  output logic              misaligned,
  output logic              is_dword
);
  localparam logic [SIZE_W-1:0] SIZE_CAP = SIZE_W'(MAX_LOG2);
  localparam logic [SIZE_W-1:0] SIZE_DW  = SIZE_W'(3);

  logic [SIZE_W-1:0] eff_size;
  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    eff_size = (size_log2 > SIZE_CAP) ? SIZE_CAP : size_log2;
    low_mask = '0;
    for (int b = 0; b < MAX_LOG2; b++) begin
      low_mask[b] = (SIZE_W'(b) < eff_size);
    end
    corrected  = addr & ~low_mask;
    misaligned = |(addr & low_mask);
    is_dword   = (eff_size == SIZE_DW);
  end
endmodule

// File: rtl/mem_fault_window.sv
module mem_fault_window #(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LO     = '0,
  parameter logic [ADDR_W-1:0] HI     = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/mem_fault_classify.sv
module mem_fault_classify
  import memchk_pkg::*;
#(
  parameter int N_WIN = NUM_WIN
) (
  input  kind_e            kind,
  input  core_e            core,
  input  logic             misaligned,
  input  logic             is_dword,
  input  logic             mask_align,
  input  logic             prot_ram_en,
  input  logic [N_WIN-1:0] hit,
  output fault_e           fault
);
  logic align_f, err_f, store_f, exc_f;
  logic b_err_win;

  always_comb begin
    align_f   = 1'b0;
    err_f     = 1'b0;
    store_f   = 1'b0;
    exc_f     = 1'b0;
    b_err_win = hit[W_ERR_MAIN] | hit[W_ERR_SIDE];
    case (core)
      CORE_A: begin
        if (kind == KIND_FETCH) begin
          // misaligned fetch is an error and skips the window test
          err_f = misaligned | hit[W_HI_FULL];
        end else if (kind != KIND_RSVD) begin
          err_f = misaligned & ~mask_align;
          if (kind == KIND_READ && is_dword && hit[W_HI_FULL]) err_f = 1'b1;
        end
      end
      CORE_B: begin
        if (kind != KIND_RSVD) align_f = misaligned;
        case (kind)
          KIND_READ:  begin err_f   = b_err_win; exc_f = hit[W_LO_FULL]; end
          KIND_WRITE: begin store_f = b_err_win; exc_f = hit[W_LO_FULL]; end
          KIND_FETCH: begin
            err_f = b_err_win;
            exc_f = hit[W_B_IEXC] | (~prot_ram_en & hit[W_B_IPRAM]);
          end
          default: ;
        endcase
      end
      CORE_C: begin
        case (kind)
          KIND_READ, KIND_WRITE: begin
            exc_f = hit[W_C_EXC_LO] | hit[W_C_EXC_HI] | (~prot_ram_en & hit[W_C_PRAM]);
            if (kind == KIND_READ) err_f = hit[W_ERR_MAIN];
            else                   store_f = hit[W_ERR_MAIN];
          end
          KIND_FETCH: begin
            err_f = hit[W_HI_FULL];
            exc_f = hit[W_C_IEXC] | (~prot_ram_en & hit[W_C_IPRAM]);
          end
          default: ;
        endcase
      end
      default: ;
    endcase

    // priority: alignment, then error classes, then exception
    if (align_f)      fault = FLT_ALIGN;
    else if (err_f)   fault = FLT_ERROR;
    else if (store_f) fault = FLT_STORE;
    else if (exc_f)   fault = FLT_EXCEPT;
    else              fault = FLT_NONE;
  end
endmodule

// File: rtl/mem_fault_chk.sv
module mem_fault_chk
  import memchk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 3,
  parameter int MAX_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_core,
  input  logic              mask_align,
  input  logic              prot_ram_en,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int MAX_LOG2 = $clog2(MAX_BYTES);

  logic [ADDR_W-1:0]  corr_addr;
  logic               mis;
  logic               dword;
  logic [NUM_WIN-1:0] win_hit;
  fault_e             fault_d;

  mem_fault_align #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_LOG2(MAX_LOG2)
  ) u_align (
    .addr(req_addr), .size_log2(req_size),
    .corrected(corr_addr), .misaligned(mis), .is_dword(dword)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] W_LO = ADDR_W'(win_lo(g));
    localparam logic [ADDR_W-1:0] W_HI = ADDR_W'(win_hi(g));
    mem_fault_window #(.ADDR_W(ADDR_W), .LO(W_LO), .HI(W_HI)) u_win (
      .addr(corr_addr), .hit(win_hit[g])
    );
  end

  mem_fault_classify #(.N_WIN(NUM_WIN)) u_cls (
    .kind(kind_e'(req_kind)), .core(core_e'(req_core)),
    .misaligned(mis), .is_dword(dword),
    .mask_align(mask_align), .prot_ram_en(prot_ram_en),
    .hit(win_hit), .fault(fault_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 3'(FLT_NONE);
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= 3'(fault_d);
        rsp_addr  <= corr_addr;
      end
    end
  end
endmodule

// File: rtl/mem_fault_chk_sva.sv
module mem_fault_chk_sva #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 3,
  parameter int MAX_BYTES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_kind,
  input logic [SIZE_W-1:0] req_size,
  input logic [1:0]        req_core,
  input logic              rsp_valid,
  input logic [2:0]        rsp_fault,
  input logic [ADDR_W-1:0] rsp_addr
);
  localparam int LOG2_CAP = $clog2(MAX_BYTES);

  function automatic logic [ADDR_W-1:0] size_mask(input logic [SIZE_W-1:0] s);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int b = 0; b < LOG2_CAP; b++) m[b] = (b < int'(s));
    return m;
  endfunction

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);                                          // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);                                        // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_fault) && $stable(rsp_addr)));         // R1
  AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ((rsp_addr & size_mask($past(req_size))) == '0));    // R2
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_addr[ADDR_W-1:LOG2_CAP] == $past(req_addr[ADDR_W-1:LOG2_CAP]))); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault <= 3'd4));                                // R3
  AST_B_MISALIGN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_core == 2'd1 && req_kind != 2'd3 &&
     (req_addr & size_mask(req_size)) != '0) |=> (rsp_fault == 3'd1)); // R4
  AST_A_NO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_core == 2'd0) |=> (rsp_fault != 3'd1));          // R5
  AST_C_NO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_core == 2'd2) |=> (rsp_fault != 3'd1));          // R12
  AST_RSVD_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_core == 2'd3 || req_kind == 2'd3)) |=> (rsp_fault == 3'd0)); // R13
endmodule

bind mem_fault_chk mem_fault_chk_sva #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES)
) i_sva (.*);

// File: tb/test_mem_fault_chk.sv
module test_mem_fault_chk;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic [2:0]  req_size;
  logic [1:0]  req_core;
  logic        mask_align;
  logic        prot_ram_en;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mem_fault_chk i_mem_fault_chk (.*);

  function automatic bit inr(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic void ref_model(input logic [31:0] a, input int kind, input int size,
      input int core, input bit mm, input bit pr,
      output int f, output logic [31:0] ca, output string tag);
    int es;
    logic [31:0] m;
    bit mis, e, x;
    es  = (size > 4) ? 4 : size;
    m   = (32'd1 << es) - 32'd1;
    mis = (a & m) != 0;
    ca  = a & ~m;
    f   = 0;
    tag = "R13";
    if (core == 3 || kind == 3) return;
    if (core == 0) begin
      tag = mis ? "R5" : "R6";
      if (kind == 2) begin
        if (mis || inr(ca, 32'hFE800000, 32'hFEFFFFFF)) f = 2;
      end else begin
        if (mis && !mm) f = 2;
        if (kind == 0 && es == 3 && inr(ca, 32'hFE800000, 32'hFEFFFFFF)) f = 2;
      end
    end else if (core == 1) begin
      e = inr(ca, 32'hFE800000, 32'hFEFEFFFF) || inr(ca, 32'hFEFF0600, 32'hFEFF7FFF);
      if (kind == 2) begin
        tag = "R9";
        x = inr(ca, 32'hFE004000, 32'hFE7FFFFF) || (!pr && inr(ca, 32'hFE000000, 32'hFE003FFF));
        f = e ? 2 : (x ? 4 : 0);
      end else begin
        tag = e ? "R7" : "R8";
        x = inr(ca, 32'hFE000000, 32'hFE7FFFFF);
        f = e ? ((kind == 1) ? 3 : 2) : (x ? 4 : 0);
      end
      if (mis) begin
        tag = (f != 0) ? "R3" : "R4";
        f = 1;
      end
    end else begin
      if (kind == 2) begin
        tag = "R11";
        e = inr(ca, 32'hFE800000, 32'hFEFFFFFF);
        x = inr(ca, 32'hFE008000, 32'hFE7FFFFF) || (!pr && inr(ca, 32'hFE000000, 32'hFE007FFF));
        f = e ? 2 : (x ? 4 : 0);
      end else begin
        tag = "R10";
        e = inr(ca, 32'hFE800000, 32'hFEFEFFFF);
        x = inr(ca, 32'hFE000000, 32'hFE3FFFFF) || inr(ca, 32'hFE408000, 32'hFE7FFFFF) ||
            (!pr && inr(ca, 32'hFE400000, 32'hFE407FFF));
        f = e ? ((kind == 1) ? 3 : 2) : (x ? 4 : 0);
      end
      if (mis) tag = "R12";
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input int kind, input int size, input int core,
                      input bit mm, input bit pr);
    int ef;
    logic [31:0] ea;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = 2'(kind); req_size = 3'(size);
    req_core = 2'(core); mask_align = mm; prot_ram_en = pr;
    ref_model(a, kind, size, core, mm, pr, ef, ea, tag);
    @(posedge clk); #1;
    check(rsp_valid == 1'b1, "R1", {31'd0, rsp_valid}, 32'd1);
    check(rsp_fault == 3'(ef), tag, {29'd0, rsp_fault}, 32'(ef));
    check(rsp_addr == ea, "R2", rsp_addr, ea);
  endtask

  logic [31:0] pts[58];

  initial begin
    logic [31:0] lo_t[11];
    logic [31:0] hi_t[11];
    logic [2:0]  held_f;
    logic [31:0] held_a;
    lo_t = '{32'hFE800000, 32'hFEFF0600, 32'hFE800000, 32'hFE000000, 32'hFE000000, 32'hFE408000,
             32'hFE400000, 32'hFE008000, 32'hFE000000, 32'hFE004000, 32'hFE000000};
    hi_t = '{32'hFEFEFFFF, 32'hFEFF7FFF, 32'hFEFFFFFF, 32'hFE7FFFFF, 32'hFE3FFFFF, 32'hFE7FFFFF,
             32'hFE407FFF, 32'hFE7FFFFF, 32'hFE007FFF, 32'hFE7FFFFF, 32'hFE003FFF};
    for (int w = 0; w < 11; w++) begin
      pts[w*5+0] = lo_t[w];
      pts[w*5+1] = lo_t[w] - 32'd11;
      pts[w*5+2] = hi_t[w] - 32'd15;
      pts[w*5+3] = hi_t[w] - 32'd2;
      pts[w*5+4] = hi_t[w] + 32'd1;
    end
    pts[55] = 32'h00000000;
    pts[56] = 32'h01234567;
    pts[57] = 32'hFFFFFFFF;

    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_size = '0;
    req_core = '0; mask_align = 1'b0; prot_ram_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(rsp_valid == 1'b0 && rsp_fault == 3'd0 && rsp_addr == 32'd0, "R1",
          {rsp_addr[28:0], rsp_fault}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 hold while idle
    send(32'hFE800003, 0, 3, 1, 1'b0, 1'b0);
    held_f = rsp_fault; held_a = rsp_addr;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'h00000010; req_core = 2'd2;
    @(posedge clk); #1;
    check(rsp_valid == 1'b0, "R1", {31'd0, rsp_valid}, 32'd0);
    check(rsp_fault == held_f && rsp_addr == held_a, "R1", rsp_addr, held_a);

    // exhaustive sweep
    for (int core = 0; core < 4; core++)
      for (int kind = 0; kind < 4; kind++)
        for (int size = 0; size < 6; size++)
          for (int ctl = 0; ctl < 4; ctl++)
            for (int p = 0; p < 58; p++)
              send(pts[p], kind, size, core, ctl[0], ctl[1]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule